// File: doc/BRIEF.md
# Multicycle complex arithmetic instruction unit

This block is the datapath behind one custom processor instruction that adds, subtracts, multiplies or divides two complex numbers. Each call of the instruction carries two data words, a one-bit step selector and an operation code, and returns one data word. The full operation (four input words, two output words) is spread over three calls. A step-0 call loads the real parts of the two operands. A step-1 call loads the imaginary parts, starts the operation and returns the real part of the result. A further step-0 call returns the imaginary part.

Inside, one adder/subtractor, one multiplier and one iterative divider are shared. A small microsequencer schedules them one operation per cycle. A division takes six products, three sums and two quotients over the denominator C²+D². Values are Q16.16 two's-complement words. Divide-by-zero and overflow flags are held until the next operation starts.

Top module: `cplx_unit`

## Requirements
- R1: A step-0 call (`step_i`=0) accepted while idle latches `opa_i` as the first operand's real part and `opb_i` as the second operand's real part. On the next cycle `done_o` is high for one cycle and `res_o` holds the imaginary part of the last completed operation, or 0 after reset.
- R2: A step-1 call accepted while idle latches `opa_i`/`opb_i` as the imaginary parts and `op_i` as the operation (00 add, 01 subtract, 10 multiply, 11 divide), and starts it. When it completes, `done_o` is high for exactly one cycle and `res_o` holds the real part of the result.
- R3: Add and subtract work component by component on 32-bit words and wrap on overflow.
- R4: Multiply returns (ac−bd) + j(ad+bc). Each product is the 64-bit signed product shifted right arithmetically by 16, keeping the low 32 bits.
- R5: Divide forms den = c·c + d·d, then nr = a·c + b·d and ni = b·c − a·d, using the products of R4 and wrapping sums. Each result part is (n·2¹⁶)/den, truncated toward zero, keeping the low 32 bits.
- R6: `dz_o` is set when the computed den is zero. This covers c=d=0 and operands so small that their squares truncate to zero. Both result parts are then 0, and the flag is never set for a non-divide operation.
- R7: `ovf_o` is set when any sum or truncated product falls outside the signed 32-bit range, or when a quotient has magnitude of 2³¹ or more.
- R8: Both flags are cleared when a step-1 call is accepted. They stay valid through the following step-0 read call.
- R9: While the schedule runs, `done_o` stays low and any call is ignored. An ignored call changes no latched operand and no result.
- R10: The step-0 call that reads the imaginary part also loads the real parts for the next operation, so operations chain back to back with two calls each.
- R11: After reset `res_o`, `done_o`, `dz_o` and `ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Instruction call strobe, one cycle |
| step_i | input | 1 | Step selector: 0 load real / read imaginary, 1 load imaginary and run |
| op_i | input | 2 | Operation code, sampled on step-1 calls |
| opa_i | input | 32 | First data word (first operand part) |
| opb_i | input | 32 | Second data word (second operand part) |
| res_o | output | 32 | Returned data word |
| done_o | output | 1 | One-cycle pulse when `res_o` is valid |
| dz_o | output | 1 | Sticky divide-by-zero flag |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The step-0 read call does two jobs at the same edge. It returns the stored imaginary part and it overwrites the real-part registers of the next operation. The bench provokes this by issuing the read call with nonzero operands and then only a step-1 call. It judges both the returned imaginary part and the next real result against its own model. A call that arrives while the schedule is still busy is also checked: it must leave no done pulse and no trace in the next result.

// File: rtl/cplx_pkg.sv
package cplx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FRAC_W = 16;

  typedef enum logic [1:0] {OP_ADD = 2'b00, OP_SUB = 2'b01, OP_MUL = 2'b10, OP_DIV = 2'b11} op_e;
  typedef enum logic [2:0] {SRC_A, SRC_B, SRC_C, SRC_D, SRC_T0, SRC_T1, SRC_T2, SRC_T3} src_e;
  typedef enum logic [2:0] {DST_T0, DST_T1, DST_T2, DST_T3, DST_RE, DST_IM} dst_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DIV_RE, ST_DIV_IM} st_e;
endpackage

// File: rtl/cplx_addsub.sv
module cplx_addsub #(
  parameter int unsigned DW = cplx_pkg::DATA_W
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          sub_i,
  output logic [DW-1:0] s_o,
  output logic          ovf_o
);
  logic [DW:0] full;
  always_comb begin
    full  = sub_i ? ({x_i[DW-1], x_i} - {y_i[DW-1], y_i})
                  : ({x_i[DW-1], x_i} + {y_i[DW-1], y_i});
    s_o   = full[DW-1:0];
    ovf_o = full[DW] ^ full[DW-1];
  end
endmodule

// File: rtl/cplx_mul.sv
module cplx_mul #(
  parameter int unsigned DW = cplx_pkg::DATA_W,
  parameter int unsigned FW = cplx_pkg::FRAC_W
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic [DW-1:0] p_o,
  output logic          ovf_o
);
  localparam int unsigned PW = 2 * DW;
  logic signed [DW-1:0] xs, ys;
  logic signed [PW-1:0] prod;
  logic [PW-DW-FW:0] hi;
  always_comb begin
    xs    = $signed(x_i);
    ys    = $signed(y_i);
    prod  = xs * ys;
    p_o   = prod[DW+FW-1:FW];
    hi    = prod[PW-1:DW+FW-1];
    ovf_o = !((&hi) || (~|hi));  // truncated value does not fit DW bits
  end
endmodule

// File: rtl/cplx_div.sv
module cplx_div #(
  parameter int unsigned DW = cplx_pkg::DATA_W,
  parameter int unsigned FW = cplx_pkg::FRAC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [DW-1:0] quo_o,
  output logic          ovf_o
);
  localparam int unsigned QW = DW + FW;
  localparam int unsigned CW = $clog2(QW + 1);

  logic [QW-1:0] dvd_q, quo_q;
  logic [DW-1:0] rem_q, dmag_q;
  logic [CW-1:0] cnt_q;
  logic          neg_q, busy_q, done_q;
  logic [DW-1:0] nmag, dmag;
  logic [DW:0]   rem_sh;
  logic          fits;

  always_comb begin
    nmag   = num_i[DW-1] ? (~num_i + 1'b1) : num_i;
    dmag   = den_i[DW-1] ? (~den_i + 1'b1) : den_i;
    rem_sh = {rem_q, dvd_q[QW-1]};
    fits   = rem_sh >= {1'b0, dmag_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q <= '0; quo_q <= '0; rem_q <= '0; dmag_q <= '0;
      cnt_q <= '0; neg_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        dvd_q  <= {nmag, {FW{1'b0}}};
        dmag_q <= dmag;
        rem_q  <= '0;
        quo_q  <= '0;
        cnt_q  <= CW'(QW);
        neg_q  <= num_i[DW-1] ^ den_i[DW-1];
        busy_q <= 1'b1;
      end else if (busy_q) begin
        dvd_q <= {dvd_q[QW-2:0], 1'b0};
        rem_q <= fits ? DW'(rem_sh - {1'b0, dmag_q}) : rem_sh[DW-1:0];
        quo_q <= {quo_q[QW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = neg_q ? (~quo_q[DW-1:0] + 1'b1) : quo_q[DW-1:0];
  assign ovf_o  = |quo_q[QW-1:DW-1];

  // R5
  div_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(busy_q));
  // R6
  div_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (den_i != '0));
endmodule

// File: rtl/cplx_unit.sv
module cplx_unit
  import cplx_pkg::*;
#(
  parameter int unsigned DW = cplx_pkg::DATA_W,
  parameter int unsigned FW = cplx_pkg::FRAC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          step_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic [DW-1:0] res_o,
  output logic          done_o,
  output logic          dz_o,
  output logic          ovf_o
);
  localparam int unsigned UW = 4;

  logic [DW-1:0] ar_q, br_q, cr_q, dr_q, t0_q, t1_q, t2_q, t3_q, re_q, im_q, res_q;
  op_e           op_q;
  st_e           st_q;
  logic [UW-1:0] uc_q;
  logic          dz_q, ov_q, done_q;

  // microstep control
  logic use_mul, sub, last, div_go;
  src_e sx, sy;
  dst_e dst;

  always_comb begin
    use_mul = 1'b0; sub = 1'b0; last = 1'b0; div_go = 1'b0;
    sx = SRC_A; sy = SRC_C; dst = DST_RE;
    unique case (op_q)
      OP_ADD, OP_SUB: begin
        sub = (op_q == OP_SUB);
        if (uc_q == '0) begin sx = SRC_A; sy = SRC_C; dst = DST_RE; end
        else begin sx = SRC_B; sy = SRC_D; dst = DST_IM; last = 1'b1; end
      end
      OP_MUL: begin
        case (uc_q)
          4'd0:    begin use_mul = 1'b1; sx = SRC_A;  sy = SRC_C;  dst = DST_T0; end
          4'd1:    begin use_mul = 1'b1; sx = SRC_B;  sy = SRC_D;  dst = DST_T1; end
          4'd2:    begin sub = 1'b1;     sx = SRC_T0; sy = SRC_T1; dst = DST_RE; end
          4'd3:    begin use_mul = 1'b1; sx = SRC_A;  sy = SRC_D;  dst = DST_T0; end
          4'd4:    begin use_mul = 1'b1; sx = SRC_B;  sy = SRC_C;  dst = DST_T1; end
          default: begin sx = SRC_T0; sy = SRC_T1; dst = DST_IM; last = 1'b1; end
        endcase
      end
      default: begin
        case (uc_q)
          4'd0:    begin use_mul = 1'b1; sx = SRC_C;  sy = SRC_C;  dst = DST_T0; end
          4'd1:    begin use_mul = 1'b1; sx = SRC_D;  sy = SRC_D;  dst = DST_T1; end
          4'd2:    begin sx = SRC_T0; sy = SRC_T1; dst = DST_T2; end
          4'd3:    begin use_mul = 1'b1; sx = SRC_A;  sy = SRC_C;  dst = DST_T0; end
          4'd4:    begin use_mul = 1'b1; sx = SRC_B;  sy = SRC_D;  dst = DST_T1; end
          4'd5:    begin sx = SRC_T0; sy = SRC_T1; dst = DST_T0; end
          4'd6:    begin use_mul = 1'b1; sx = SRC_B;  sy = SRC_C;  dst = DST_T1; end
          4'd7:    begin use_mul = 1'b1; sx = SRC_A;  sy = SRC_D;  dst = DST_T3; end
          4'd8:    begin sub = 1'b1;     sx = SRC_T1; sy = SRC_T3; dst = DST_T1; end
          default: div_go = 1'b1;
        endcase
      end
    endcase
  end

  function automatic logic [DW-1:0] pick(input src_e s, input logic [DW-1:0] a, b, c, d,
                                         input logic [DW-1:0] t0, t1, t2, t3);
    case (s)
      SRC_A:   return a;
      SRC_B:   return b;
      SRC_C:   return c;
      SRC_D:   return d;
      SRC_T0:  return t0;
      SRC_T1:  return t1;
      SRC_T2:  return t2;
      default: return t3;
    endcase
  endfunction

  logic [DW-1:0] xv, yv, add_s, mul_p, wv, div_num, div_quo;
  logic          add_ov, mul_ov, wov, div_start, div_done, div_ov;

  assign xv = pick(sx, ar_q, br_q, cr_q, dr_q, t0_q, t1_q, t2_q, t3_q);
  assign yv = pick(sy, ar_q, br_q, cr_q, dr_q, t0_q, t1_q, t2_q, t3_q);

  cplx_addsub #(.DW(DW)) u_add (.x_i(xv), .y_i(yv), .sub_i(sub), .s_o(add_s), .ovf_o(add_ov));
  cplx_mul #(.DW(DW), .FW(FW)) u_mul (.x_i(xv), .y_i(yv), .p_o(mul_p), .ovf_o(mul_ov));

  assign wv        = use_mul ? mul_p : add_s;
  assign wov       = use_mul ? mul_ov : add_ov;
  assign div_num   = (st_q == ST_RUN) ? t0_q : t1_q;
  assign div_start = ((st_q == ST_RUN) && div_go && (t2_q != '0)) ||
                     ((st_q == ST_DIV_RE) && div_done);

  cplx_div #(.DW(DW), .FW(FW)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start), .num_i(div_num), .den_i(t2_q),
    .done_o(div_done), .quo_o(div_quo), .ovf_o(div_ov)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0; br_q <= '0; cr_q <= '0; dr_q <= '0;
      t0_q <= '0; t1_q <= '0; t2_q <= '0; t3_q <= '0;
      re_q <= '0; im_q <= '0; res_q <= '0;
      op_q <= OP_ADD; st_q <= ST_IDLE; uc_q <= '0;
      dz_q <= 1'b0; ov_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (call_i) begin
          if (!step_i) begin
            ar_q <= opa_i; cr_q <= opb_i;
            res_q <= im_q; done_q <= 1'b1;
          end else begin
            br_q <= opa_i; dr_q <= opb_i; op_q <= op_e'(op_i);
            dz_q <= 1'b0; ov_q <= 1'b0; uc_q <= '0; st_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          uc_q <= uc_q + 1'b1;
          if (div_go) begin
            if (t2_q == '0) begin
              dz_q <= 1'b1; re_q <= '0; im_q <= '0; res_q <= '0;
              done_q <= 1'b1; st_q <= ST_IDLE;
            end else begin
              st_q <= ST_DIV_RE;
            end
          end else begin
            ov_q <= ov_q | wov;
            case (dst)
              DST_T0:  t0_q <= wv;
              DST_T1:  t1_q <= wv;
              DST_T2:  t2_q <= wv;
              DST_T3:  t3_q <= wv;
              DST_RE:  re_q <= wv;
              default: im_q <= wv;
            endcase
            if (last) begin
              res_q <= re_q; done_q <= 1'b1; st_q <= ST_IDLE;
            end
          end
        end
        ST_DIV_RE: if (div_done) begin
          re_q <= div_quo; ov_q <= ov_q | div_ov; st_q <= ST_DIV_IM;
        end
        default: if (div_done) begin
          im_q <= div_quo; ov_q <= ov_q | div_ov;
          res_q <= re_q; done_q <= 1'b1; st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign res_o  = res_q;
  assign done_o = done_q;
  assign dz_o   = dz_q;
  assign ovf_o  = ov_q;

  // R9
  busy_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> !done_q);
  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && step_i && st_q == ST_IDLE) |=> (!dz_q && !ov_q));
  // R6
  dz_only_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_q |-> (op_q == OP_DIV));
  // R1
  read_imag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !step_i && st_q == ST_IDLE) |=> (done_q && res_q == $past(im_q)));
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !$past(call_i)) |=> !done_q);
endmodule

// File: tb/sim_cplx_unit.sv
`timescale 1ns/1ps
module sim_cplx_unit;
  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;
  localparam int NV = 11;
  // {op, a, b, c, d}
  localparam logic [129:0] VEC [NV] = '{
    {2'b00, 32'h0001_8000, 32'h0002_0000, 32'h0000_4000, 32'hFFFF_0000},
    {2'b01, 32'h0003_0000, 32'h0001_0000, 32'h0005_0000, 32'hFFFE_0000},
    {2'b10, 32'h0001_0000, 32'h0002_0000, 32'h0003_0000, 32'h0004_0000},
    {2'b10, 32'hFFFF_8000, 32'h0000_4000, 32'h0002_8000, 32'hFFFF_C000},
    {2'b11, 32'h0001_0000, 32'h0002_0000, 32'h0003_0000, 32'h0004_0000},
    {2'b11, 32'hFFF9_0000, 32'h0001_0000, 32'h0000_0000, 32'h0002_0000},
    {2'b00, 32'h7FFF_0000, 32'h0000_0000, 32'h0002_0000, 32'h0000_0000},
    {2'b10, 32'h0100_0000, 32'h0000_0000, 32'h0100_0000, 32'h0000_0000},
    {2'b11, 32'h0001_0000, 32'h0001_0000, 32'h0000_0000, 32'h0000_0000},
    {2'b11, 32'h7FFF_0000, 32'h0000_0000, 32'h0000_0100, 32'h0000_0000},
    {2'b11, 32'h0001_0000, 32'h0000_0000, 32'h0000_0010, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic call = 1'b0, step = 1'b0;
  logic [1:0] op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] res;
  logic done, dz, ovf;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cplx_unit u0 (.clk_i(clk), .rst_ni(rst_n), .call_i(call), .step_i(step), .op_i(op),
                .opa_i(opa), .opb_i(opb), .res_o(res), .done_o(done), .dz_o(dz), .ovf_o(ovf));

  function automatic logic [31:0] m_add(input logic [31:0] x, y, input bit s, inout logic ov);
    longint r = s ? (longint'($signed(x)) - longint'($signed(y)))
                  : (longint'($signed(x)) + longint'($signed(y)));
    if (r > MAXV || r < MINV) ov = 1'b1;
    return r[31:0];
  endfunction

  function automatic logic [31:0] m_mul(input logic [31:0] x, y, inout logic ov);
    longint r = (longint'($signed(x)) * longint'($signed(y))) >>> 16;
    if (r > MAXV || r < MINV) ov = 1'b1;
    return r[31:0];
  endfunction

  function automatic logic [31:0] m_div(input logic [31:0] n, den, inout logic ov);
    longint q = (longint'($signed(n)) * 64'sd65536) / longint'($signed(den));
    if (q > MAXV || q <= MINV) ov = 1'b1;
    return q[31:0];
  endfunction

  task automatic model(input logic [1:0] o, input logic [31:0] a, b, c, d,
                       output logic [31:0] re, im, output logic dzx, ovx);
    logic [31:0] den, nr, ni;
    dzx = 1'b0; ovx = 1'b0;
    case (o)
      2'b00, 2'b01: begin
        re = m_add(a, c, o[0], ovx); im = m_add(b, d, o[0], ovx);
      end
      2'b10: begin
        re = m_add(m_mul(a, c, ovx), m_mul(b, d, ovx), 1'b1, ovx);
        im = m_add(m_mul(a, d, ovx), m_mul(b, c, ovx), 1'b0, ovx);
      end
      default: begin
        den = m_add(m_mul(c, c, ovx), m_mul(d, d, ovx), 1'b0, ovx);
        nr  = m_add(m_mul(a, c, ovx), m_mul(b, d, ovx), 1'b0, ovx);
        ni  = m_add(m_mul(b, c, ovx), m_mul(a, d, ovx), 1'b1, ovx);
        if (den == '0) begin dzx = 1'b1; re = '0; im = '0; end
        else begin re = m_div(nr, den, ovx); im = m_div(ni, den, ovx); end
      end
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] got, exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_call(input bit n, input logic [1:0] o, input logic [31:0] x, y);
    @(negedge clk); call = 1'b1; step = n; op = o; opa = x; opb = y;
    @(negedge clk); call = 1'b0; step = 1'b0; opa = '0; opb = '0;
  endtask

  task automatic wait_done(input string tag);
    for (int i = 0; i < 400; i++) begin
      if (done === 1'b1) return;
      @(negedge clk);
    end
    chk({tag, " done timeout"}, 32'd0, 32'd1);
  endtask

  task automatic run_op(input string tag, input logic [1:0] o, input logic [31:0] a, b, c, d,
                        input bit load_real);
    logic [31:0] er, ei; logic edz, eov;
    model(o, a, b, c, d, er, ei, edz, eov);
    if (load_real) do_call(1'b0, 2'b00, a, c);
    do_call(1'b1, o, b, d);
    wait_done(tag);
    chk({tag, " R2/R3/R4/R5 real"}, res, er);
    @(negedge clk);
    chk({tag, " R2 done single pulse"}, {31'd0, done}, 32'd0);
    do_call(1'b0, 2'b00, 32'd0, 32'd0);
    chk({tag, " R1 read done"}, {31'd0, done}, 32'd1);
    chk({tag, " R1/R3/R4/R5 imag"}, res, ei);
    chk({tag, " R6 dz"}, {31'd0, dz}, {31'd0, edz});
    chk({tag, " R7/R8 ovf"}, {31'd0, ovf}, {31'd0, eov});
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired got=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] er, ei; logic edz, eov;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 res", res, 32'd0);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 dz", {31'd0, dz}, 32'd0);
    chk("R11 ovf", {31'd0, ovf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_call(1'b0, 2'b00, 32'd0, 32'd0);
    chk("R1 imag after reset", res, 32'd0);

    for (int v = 0; v < NV; v++)
      run_op($sformatf("vec%0d", v), VEC[v][129:128], VEC[v][127:96], VEC[v][95:64],
             VEC[v][63:32], VEC[v][31:0], 1'b1);

    // R9: call during divide is ignored, no done pulse, no operand change
    do_call(1'b0, 2'b00, 32'h0002_0000, 32'h0001_0000);
    do_call(1'b1, 2'b11, 32'h0000_8000, 32'h0001_0000);
    do_call(1'b0, 2'b00, 32'h0012_3450, 32'h0006_7890);
    chk("R9 no done while busy", {31'd0, done}, 32'd0);
    model(2'b11, 32'h0002_0000, 32'h0000_8000, 32'h0001_0000, 32'h0001_0000, er, ei, edz, eov);
    wait_done("R9 div");
    chk("R9 div real", res, er);
    do_call(1'b0, 2'b00, 32'd0, 32'd0);
    chk("R9 div imag", res, ei);
    // real parts now zero from the read call; add uses them
    run_op("R10 zero reals", 2'b00, 32'd0, 32'h0003_0000, 32'd0, 32'h0000_1000, 1'b0);

    // R10: read call carries next real parts
    model(2'b10, 32'h0001_0000, 32'h0001_0000, 32'h0002_0000, 32'hFFFF_0000, er, ei, edz, eov);
    do_call(1'b0, 2'b00, 32'h0001_0000, 32'h0002_0000);
    do_call(1'b1, 2'b10, 32'h0001_0000, 32'hFFFF_0000);
    wait_done("R10 mul");
    chk("R10 chained real", res, er);
    do_call(1'b0, 2'b00, 32'h0004_0000, 32'h0001_0000);
    chk("R10 chained imag", res, ei);
    model(2'b01, 32'h0004_0000, 32'h0000_2000, 32'h0001_0000, 32'h0000_1000, er, ei, edz, eov);
    do_call(1'b1, 2'b01, 32'h0000_2000, 32'h0000_1000);
    wait_done("R10 sub");
    chk("R10 second chained real", res, er);
    do_call(1'b0, 2'b00, 32'd0, 32'd0);
    chk("R10 second chained imag", res, ei);

    // R8: flags set then cleared by next operation
    run_op("R8 set", 2'b10, 32'h0100_0000, 32'd0, 32'h0100_0000, 32'd0, 1'b1);
    chk("R8 ovf held after read", {31'd0, ovf}, 32'd1);
    run_op("R8 clear", 2'b00, 32'h0001_0000, 32'd0, 32'h0001_0000, 32'd0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule